// File: doc/BRIEF.md
# USB Device Mode and NAK Interrupt Qualifier

This block holds the mode byte and the configured flag of a USB device controller. Each time the packet engine finishes an endpoint transaction, the block decides whether that transaction raises an endpoint interrupt. Software reaches the block through a small command port. A one-cycle command strobe carries a code. A data-byte strobe then follows within a bounded window and supplies the value for the register that the code selects.

The packet engine reports each transaction with four things:
- a one-cycle done strobe;
- the endpoint type;
- the direction;
- whether the transaction was NAKed.

A successful transaction always produces an interrupt pulse. A NAKed one produces a pulse only when the mode byte enables NAK interrupts for that type and direction. For the two OUT classes, an active DMA flag also blocks the NAK interrupt.

The block drives three further outputs from its state:
- a request that keeps the 48 MHz clock running;
- an active-low status LED;
- the response enable for non-control endpoints.

Top module: `usb_mode_qual`

## Requirements
- R1: After reset, the following hold:
  - `modeByte` reads 0x00.
  - `configured` is 0.
  - `ledN` is 1.
  - `epIrq` is 0 while `xferDone` is low.
- R2: Command code 0xF3 followed by a data byte writes bits 6:0 of the data into the mode byte. Bit 7 of `modeByte` always reads 0, whatever is written. The new value is visible after the clock edge that samples the data strobe.
- R3: Command code 0xD8 followed by a data byte loads `configured` from bit 0 of the data and ignores the other data bits.
- R4: The following are all discarded, and the registers keep their values:
  - a data byte that arrives after the 16 cycles following its command strobe (the data strobe sampled in cycles 1 to 16 after the command is accepted);
  - a data byte with no pending command;
  - a command code other than 0xF3 or 0xD8.
- R5: `clkReq` is 1 whenever mode bit 0 is set. When mode bit 0 is clear, `clkReq` equals the inverse of `suspend`.
- R6: Mode bits 1 to 6 enable interrupts on NAKed transactions for six classes, in this order:

  | Mode bit | Class |
  |---|---|
  | 1 | control IN |
  | 2 | control OUT |
  | 3 | interrupt IN |
  | 4 | interrupt OUT |
  | 5 | bulk IN |
  | 6 | bulk OUT |

  The `xferType` encoding is 0 for control, 1 for interrupt and 2 for bulk. `xferDirIn` is 1 for IN.
- R7: A successful transaction (`xferNak`=0) of type 0, 1 or 2 raises `epIrq` in the same cycle as `xferDone`. `epIrqIdx` equals `xferEp` in that cycle. Type 3 never raises an interrupt.
- R8: While `dmaIntOut` is 1, NAKed interrupt OUT transactions raise no interrupt. While `dmaBulkOut` is 1, NAKed bulk OUT transactions raise no interrupt. In both cases this holds whatever the mode bit says, and successful transactions are unaffected.
- R9: A cycle with `busReset` high clears `configured` at the next edge. This takes priority over a configuration write in the same cycle.
- R10: `ledN` is 0 exactly when `configured` is 1 and `suspend` is 0.
- R11: `respEnable`, the response enable for non-control endpoints, equals `configured`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command code strobe |
| cmdCode | input | 8 | Command code |
| dataValid | input | 1 | Data byte strobe |
| dataByte | input | 8 | Data byte |
| busReset | input | 1 | USB bus reset seen |
| suspend | input | 1 | Device is suspended |
| dmaIntOut | input | 1 | DMA active on interrupt OUT endpoints |
| dmaBulkOut | input | 1 | DMA active on bulk OUT endpoints |
| xferDone | input | 1 | Transaction finished strobe |
| xferType | input | 2 | Endpoint type: 0 control, 1 interrupt, 2 bulk |
| xferDirIn | input | 1 | 1 for IN, 0 for OUT |
| xferNak | input | 1 | Transaction was NAKed |
| xferEp | input | EP_W | Endpoint index of the transaction |
| epIrq | output | 1 | Endpoint interrupt pulse |
| epIrqIdx | output | EP_W | Endpoint index with the pulse |
| modeByte | output | 8 | Mode register read-back |
| configured | output | 1 | Configured flag |
| clkReq | output | 1 | Clock-keep request |
| ledN | output | 1 | Active-low status LED |
| respEnable | output | 1 | Non-control endpoints may respond |

## Verification
The assertions assume the following about the inputs:
- `xferDone` is a single-cycle strobe with its qualifiers valid in the same cycle.
- A data strobe never coincides with a new command strobe.
- Reset is held for at least one edge before checking starts.

The stimulus drives every input on the falling edge and issues commands and data bytes on separate cycles. It also keeps `xferDone` low while the command port is in use, so the qualifier is always exercised against a settled mode byte.

// File: rtl/usb_mode_pkg.sv
package usb_mode_pkg;

  typedef enum logic [1:0] {
    EP_CTRL = 2'd0,
    EP_INTR = 2'd1,
    EP_BULK = 2'd2,
    EP_RSVD = 2'd3
  } epKind_t;

  localparam logic [7:0] CMD_SET_MODE = 8'hF3;
  localparam logic [7:0] CMD_SET_CONF = 8'hD8;

  // Bit positions in the NAK-enable vector built from mode bits 6:1.
  localparam int NAK_CTRL_IN  = 0;
  localparam int NAK_CTRL_OUT = 1;
  localparam int NAK_INTR_IN  = 2;
  localparam int NAK_INTR_OUT = 3;
  localparam int NAK_BULK_IN  = 4;
  localparam int NAK_BULK_OUT = 5;
  localparam int NAK_CLASSES  = 6;

  typedef struct packed {
    logic writeMode;
    logic writeConf;
  } regStrobe_t;

endpackage

// File: rtl/usb_mode_ctrl.sv
module usb_mode_ctrl
  import usb_mode_pkg::*;
#(
  parameter int DATA_WAIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic       dataValid,
  output regStrobe_t strobe
);

  localparam int CNT_W = (DATA_WAIT > 1) ? $clog2(DATA_WAIT) : 1;
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(DATA_WAIT - 1);

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT_MODE,
    S_WAIT_CONF
  } cmdState_t;

  cmdState_t        state;
  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else if (cmdValid) begin
      waitCnt <= '0;
      case (cmdCode)
        CMD_SET_MODE: state <= S_WAIT_MODE;
        CMD_SET_CONF: state <= S_WAIT_CONF;
        default:      state <= S_IDLE;
      endcase
    end else if (state != S_IDLE) begin
      if (dataValid || waitCnt == LAST_WAIT) begin
        state   <= S_IDLE;
        waitCnt <= '0;
      end else begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.writeMode = dataValid && (state == S_WAIT_MODE);
    strobe.writeConf = dataValid && (state == S_WAIT_CONF);
  end

endmodule

// File: rtl/usb_mode_dp.sv
module usb_mode_dp
  import usb_mode_pkg::*;
#(
  parameter int EP_W = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  regStrobe_t      strobe,
  input  logic [7:0]      dataByte,
  input  logic            busReset,
  input  logic            suspend,
  input  logic            dmaIntOut,
  input  logic            dmaBulkOut,
  input  logic            xferDone,
  input  logic [1:0]      xferType,
  input  logic            xferDirIn,
  input  logic            xferNak,
  input  logic [EP_W-1:0] xferEp,
  output logic            epIrq,
  output logic [EP_W-1:0] epIrqIdx,
  output logic [7:0]      modeByte,
  output logic            configured,
  output logic            clkReq,
  output logic            ledN,
  output logic            respEnable
);

  logic [6:0]             modeReg;
  logic                   confReg;
  logic [NAK_CLASSES-1:0] dmaBlock;
  logic [7:0]             nakAllow;
  logic [2:0]             classIdx;
  epKind_t                kind;
  logic                   kindValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
    end else if (strobe.writeMode) begin
      modeReg <= dataByte[6:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || busReset) begin
      confReg <= 1'b0;
    end else if (strobe.writeConf) begin
      confReg <= dataByte[0];
    end
  end

  // Only the two OUT classes can be blocked by an active DMA channel.
  for (genvar c = 0; c < NAK_CLASSES; c++) begin : g_dma
    if (c == NAK_INTR_OUT) begin : g_int
      assign dmaBlock[c] = dmaIntOut;
    end else if (c == NAK_BULK_OUT) begin : g_bulk
      assign dmaBlock[c] = dmaBulkOut;
    end else begin : g_none
      assign dmaBlock[c] = 1'b0;
    end
  end

  always_comb begin
    kind      = epKind_t'(xferType);
    kindValid = (kind != EP_RSVD);
    classIdx  = {xferType, ~xferDirIn};
    nakAllow  = {2'b00, modeReg[6:1] & ~dmaBlock};
  end

  assign epIrq      = xferDone && kindValid && (!xferNak || nakAllow[classIdx]);
  assign epIrqIdx   = xferEp;
  assign modeByte   = {1'b0, modeReg};
  assign configured = confReg;
  assign clkReq     = modeReg[0] || !suspend;
  assign ledN       = !(confReg && !suspend);
  assign respEnable = confReg;

endmodule

// File: rtl/usb_mode_qual.sv
module usb_mode_qual
  import usb_mode_pkg::*;
#(
  parameter int EP_W      = 5,
  parameter int DATA_WAIT = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [7:0]      cmdCode,
  input  logic            dataValid,
  input  logic [7:0]      dataByte,
  input  logic            busReset,
  input  logic            suspend,
  input  logic            dmaIntOut,
  input  logic            dmaBulkOut,
  input  logic            xferDone,
  input  logic [1:0]      xferType,
  input  logic            xferDirIn,
  input  logic            xferNak,
  input  logic [EP_W-1:0] xferEp,
  output logic            epIrq,
  output logic [EP_W-1:0] epIrqIdx,
  output logic [7:0]      modeByte,
  output logic            configured,
  output logic            clkReq,
  output logic            ledN,
  output logic            respEnable
);

  regStrobe_t strobe;

  usb_mode_ctrl #(.DATA_WAIT(DATA_WAIT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdCode   (cmdCode),
    .dataValid (dataValid),
    .strobe    (strobe)
  );

  usb_mode_dp #(.EP_W(EP_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dataByte   (dataByte),
    .busReset   (busReset),
    .suspend    (suspend),
    .dmaIntOut  (dmaIntOut),
    .dmaBulkOut (dmaBulkOut),
    .xferDone   (xferDone),
    .xferType   (xferType),
    .xferDirIn  (xferDirIn),
    .xferNak    (xferNak),
    .xferEp     (xferEp),
    .epIrq      (epIrq),
    .epIrqIdx   (epIrqIdx),
    .modeByte   (modeByte),
    .configured (configured),
    .clkReq     (clkReq),
    .ledN       (ledN),
    .respEnable (respEnable)
  );

endmodule

// File: rtl/usb_mode_checker.sv
module usb_mode_checker (
  input logic       clk,
  input logic       rstN,
  input logic       dataValid,
  input logic       busReset,
  input logic       suspend,
  input logic       dmaBulkOut,
  input logic       dmaIntOut,
  input logic       xferDone,
  input logic [1:0] xferType,
  input logic       xferDirIn,
  input logic       xferNak,
  input logic       epIrq,
  input logic [7:0] modeByte,
  input logic       configured,
  input logic       clkReq,
  input logic       ledN,
  input logic       respEnable
);

  // Set after the first edge out of reset, so $past never looks before reset.
  logic started;
  always_ff @(posedge clk) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  p_mode_bit7_r2: assert property (@(posedge clk) disable iff (!rstN)
    modeByte[7] == 1'b0);

  p_mode_needs_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    (started && !$past(dataValid)) |-> $stable(modeByte));

  p_clk_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeByte[0] || !suspend) |-> clkReq);

  p_irq_needs_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    epIrq |-> xferDone);

  p_rsvd_type_r7: assert property (@(posedge clk) disable iff (!rstN)
    (xferType == 2'd3) |-> !epIrq);

  p_dma_bulk_r8: assert property (@(posedge clk) disable iff (!rstN)
    (epIrq && xferNak && xferType == 2'd2 && !xferDirIn) |-> !dmaBulkOut);

  p_dma_intr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (epIrq && xferNak && xferType == 2'd1 && !xferDirIn) |-> !dmaIntOut);

  p_bus_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> !configured);

  p_led_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ledN |-> (configured && !suspend));

  p_resp_r11: assert property (@(posedge clk) disable iff (!rstN)
    respEnable == configured);

endmodule

bind usb_mode_qual usb_mode_checker u_chk (.*);

// File: tb/usb_mode_qual_bench.sv
module usb_mode_qual_bench;

  localparam int EP_W = 5;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cmdValid = 1'b0;
  logic [7:0]      cmdCode = '0;
  logic            dataValid = 1'b0;
  logic [7:0]      dataByte = '0;
  logic            busReset = 1'b0;
  logic            suspend = 1'b0;
  logic            dmaIntOut = 1'b0;
  logic            dmaBulkOut = 1'b0;
  logic            xferDone = 1'b0;
  logic [1:0]      xferType = '0;
  logic            xferDirIn = 1'b0;
  logic            xferNak = 1'b0;
  logic [EP_W-1:0] xferEp = '0;
  logic            epIrq;
  logic [EP_W-1:0] epIrqIdx;
  logic [7:0]      modeByte;
  logic            configured;
  logic            clkReq;
  logic            ledN;
  logic            respEnable;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  usb_mode_qual #(.EP_W(EP_W)) u_usb_mode_qual (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Command on one falling edge, data after `gap` further idle cycles.
  task automatic sendCmd(input logic [7:0] code, input logic [7:0] val, input int gap);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdCode  = code;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (gap) @(negedge clk);
    dataValid = 1'b1;
    dataByte  = val;
    @(negedge clk);
    dataValid = 1'b0;
  endtask

  // Drive one transaction and sample the combinational pulse mid-cycle.
  task automatic xfer(input logic [1:0] t, input logic dIn, input logic nak,
                      input logic [EP_W-1:0] ep, input logic expIrq, input string req);
    @(negedge clk);
    xferDone  = 1'b1;
    xferType  = t;
    xferDirIn = dIn;
    xferNak   = nak;
    xferEp    = ep;
    #2;
    chk(req, {31'b0, epIrq}, {31'b0, expIrq});
    if (expIrq) chk({req, " idx"}, 32'(epIrqIdx), 32'(ep));
    @(negedge clk);
    xferDone = 1'b0;
  endtask

  // Each entry: {type[1:0], dirIn, nak, dmaIntOut, dmaBulkOut, expectedIrq}
  // Mode 0x54 enables NAK interrupts on control OUT, interrupt OUT and bulk OUT (R6).
  localparam logic [6:0] VEC [12] = '{
    7'b00_1_1_0_0_0,  // control IN NAK, bit1 clear
    7'b00_0_1_0_0_1,  // control OUT NAK, bit2 set
    7'b01_1_1_0_0_0,  // interrupt IN NAK, bit3 clear
    7'b01_0_1_0_0_1,  // interrupt OUT NAK, bit4 set
    7'b01_0_1_1_0_0,  // interrupt OUT NAK with DMA (R8)
    7'b10_1_1_0_0_0,  // bulk IN NAK, bit5 clear
    7'b10_0_1_0_0_1,  // bulk OUT NAK, bit6 set
    7'b10_0_1_0_1_0,  // bulk OUT NAK with DMA (R8)
    7'b10_0_0_0_1_1,  // bulk OUT success with DMA (R8)
    7'b00_1_0_0_0_1,  // control IN success (R7)
    7'b11_1_0_0_0_0,  // reserved type (R7)
    7'b01_0_1_0_1_1   // interrupt OUT NAK, only bulk DMA set (R8)
  };

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1 mode", 32'(modeByte), 32'h00);
    chk("R1 conf", {31'b0, configured}, 32'd0);
    chk("R1 led", {31'b0, ledN}, 32'd1);
    chk("R1 irq", {31'b0, epIrq}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R2: write the mode byte; bit 7 reads back 0.
    sendCmd(8'hF3, 8'hD4, 0);
    #2;
    chk("R2 mode write", 32'(modeByte), 32'h54);

    // R6 R7 R8: walk the table.
    for (int i = 0; i < 12; i++) begin
      dmaIntOut  = VEC[i][2];
      dmaBulkOut = VEC[i][1];
      xfer(VEC[i][6:5], VEC[i][4], VEC[i][3], EP_W'(i + 3), VEC[i][0], "R6/R7/R8 vector");
    end
    dmaIntOut  = 1'b0;
    dmaBulkOut = 1'b0;

    // R6: opposite pattern 0x2A enables control IN, interrupt IN and bulk IN.
    sendCmd(8'hF3, 8'h2A, 3);
    #2;
    chk("R6 mode 2A", 32'(modeByte), 32'h2A);
    xfer(2'd0, 1'b1, 1'b1, 5'd1, 1'b1, "R6 ctrl IN nak");
    xfer(2'd2, 1'b0, 1'b1, 5'd2, 1'b0, "R6 bulk OUT nak");
    xfer(2'd2, 1'b1, 1'b1, 5'd4, 1'b1, "R6 bulk IN nak");

    // R5: clock request follows suspend unless mode bit 0 is set.
    suspend = 1'b1;
    #2;
    chk("R5 suspend no keep", {31'b0, clkReq}, 32'd0);
    sendCmd(8'hF3, 8'h01, 0);
    #2;
    chk("R5 keep", {31'b0, clkReq}, 32'd1);
    suspend = 1'b0;
    #2;
    chk("R5 awake", {31'b0, clkReq}, 32'd1);

    // R3 R10 R11: configure with extra bits set in the data.
    sendCmd(8'hD8, 8'hFF, 1);
    #2;
    chk("R3 conf set", {31'b0, configured}, 32'd1);
    chk("R10 led on", {31'b0, ledN}, 32'd0);
    chk("R11 resp", {31'b0, respEnable}, 32'd1);
    suspend = 1'b1;
    #2;
    chk("R10 led suspended", {31'b0, ledN}, 32'd1);
    suspend = 1'b0;
    sendCmd(8'hD8, 8'hFE, 0);
    #2;
    chk("R3 conf clear", {31'b0, configured}, 32'd0);
    chk("R11 resp off", {31'b0, respEnable}, 32'd0);

    // R4: data in the 16th cycle is accepted, in the 17th it is discarded.
    sendCmd(8'hF3, 8'h33, 15);
    #2;
    chk("R4 last window cycle", 32'(modeByte), 32'h33);
    sendCmd(8'hF3, 8'h44, 16);
    #2;
    chk("R4 late data", 32'(modeByte), 32'h33);
    @(negedge clk);
    dataValid = 1'b1;
    dataByte  = 8'h55;
    @(negedge clk);
    dataValid = 1'b0;
    #2;
    chk("R4 stray data", 32'(modeByte), 32'h33);
    sendCmd(8'hA5, 8'h66, 0);
    #2;
    chk("R4 unknown code", 32'(modeByte), 32'h33);

    // R9: bus reset wins over a configuration write in the same cycle.
    sendCmd(8'hD8, 8'h01, 0);
    @(negedge clk);
    busReset = 1'b1;
    @(negedge clk);
    busReset = 1'b0;
    #2;
    chk("R9 bus reset", {31'b0, configured}, 32'd0);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdCode  = 8'hD8;
    @(negedge clk);
    cmdValid  = 1'b0;
    dataValid = 1'b1;
    dataByte  = 8'h01;
    busReset  = 1'b1;
    @(negedge clk);
    dataValid = 1'b0;
    busReset  = 1'b0;
    #2;
    chk("R9 priority", {31'b0, configured}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule